// File: doc/BRIEF.md
# Fractional Halving-Add Execution Slice

This block is a single-cycle execution slice for one signed fractional word operation. It takes one 32-bit instruction word and decodes it. When the word matches the halving-add encoding, the slice reads two 32-bit source registers from its own 32-entry register file. It adds them as 33-bit sign-extended values and keeps the upper 32 bits of that sum. The sum is never saturated. A single bit in the instruction selects an optional +1 before the halving shift, which gives round-to-nearest in place of a floor. The result is presented on a write port in the same cycle and lands in the destination register on the next rising clock edge.

Register reads are combinational. An instruction may therefore name its own destination as a source, and it may consume the previous instruction's result with no stall. A separate load port fills the register file from elsewhere in the pipeline. The slice reports two exceptions and suppresses the register write when either is raised. One exception covers a valid word that does not carry this encoding. The other covers a matching word issued while the DSP resources are disabled.

Top module: `fhadd_unit`

## Requirements
- R1: A word is this instruction only when bits 31:26 = 001000, bits 9:3 = 0010001 and bits 2:0 = 101. Its fields are: second source index in bits 25:21, first source index in bits 20:16, destination index in bits 15:11, and rounding select in bit 10. With `instr_valid` and `dsp_enable` high, a matching word raises `res_valid` and drives `res_addr` with bits 15:11.
- R2: With bit 10 = 0, `res_data` equals bits 32..1 of the 33-bit sum of both sources, each sign-extended from bit 31. This is an arithmetic halving that rounds toward minus infinity.
- R3: With bit 10 = 1, a 1 is added at bit 0 of the 33-bit sum before bits 32..1 are taken.
- R4: No saturation or overflow indication exists. 0x7FFFFFFF with itself gives 0x7FFFFFFF, and 0x80000000 with itself gives 0x80000000, in both forms. 0xFFFFFFFF with 0 gives 0xFFFFFFFF plain and 0 rounded.
- R5: The result is stored into the destination register on the rising edge that ends the issuing cycle. Reads are combinational, so the next instruction sees the new value, and a destination equal to a source is allowed.
- R6: A valid matching word with `dsp_enable` low raises `exc_dsp_off` and not `res_valid`, and no register changes.
- R7: A valid word that mismatches bits 31:26, 9:3 or 2:0 raises `exc_reserved` regardless of `dsp_enable`. It does not raise `res_valid` or `exc_dsp_off`, and no register changes. Neither exception is raised while `instr_valid` is low.
- R8: Register 0 always reads as zero. A result or load addressed to it has no effect.
- R9: `load_en` writes `load_data` into entry `load_addr` on the next rising edge. When a result write happens in the same cycle, only the result is stored and the load is dropped.
- R10: A synchronous active-low reset clears every register to zero. With `instr_valid` low, `res_valid` and both exceptions are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr_word | input | 32 | Instruction word to decode |
| dsp_enable | input | 1 | DSP resources are enabled |
| load_en | input | 1 | Register-file load request |
| load_addr | input | 5 | Register index for the load |
| load_data | input | 32 | Value to load |
| res_valid | output | 1 | A result write to `res_addr` takes effect at the next edge |
| res_addr | output | 5 | Destination register index |
| res_data | output | 32 | Halved (optionally rounded) sum |
| exc_reserved | output | 1 | Valid word does not carry this encoding |
| exc_dsp_off | output | 1 | Matching word issued with DSP resources disabled |

## Verification
A corrupted register entry shows up at the ports as soon as any instruction names it as a source, in that same cycle. Register contents are read back with the rounding form using equal sources and destination 0, which returns the stored value unchanged and writes nothing. A wrong sign extension or a misplaced rounding bit appears on `res_data` in the issuing cycle. The corner-case operands at the ends of the signed range expose this most readily. A decode fault that lets a write through on an exception shows up one cycle later, when the destination is read back.

// File: rtl/fhadd_pkg.sv
// Package: shared constants and field layout for the halving-add slice.
// Assumes the fixed 32-bit instruction layout with 5-bit register indices.
package fhadd_pkg;

    localparam int INSN_W = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] MAJOR_CODE = 6'b001000;
    localparam logic [6:0] SUB_CODE   = 7'b0010001;
    localparam logic [2:0] MINOR_CODE = 3'b101;

    // Field layout, most significant field first; the decoder relies on it.
    typedef struct packed {
        logic [5:0]        major;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] dst;
        logic              rnd;
        logic [6:0]        sub;
        logic [2:0]        minor;
    } hadd_word_t;

    typedef enum logic [1:0] {
        OUTCOME_IDLE     = 2'd0,
        OUTCOME_WRITE    = 2'd1,
        OUTCOME_RESERVED = 2'd2,
        OUTCOME_DSP_OFF  = 2'd3
    } outcome_t;

endpackage

// File: rtl/fhadd_decode.sv
// Module: fhadd_decode
// Splits an instruction word into fields and classifies the issue outcome.
// An encoding mismatch outranks the DSP-disabled condition, because a
// word that is not this instruction cannot be blamed on DSP state.
// Purely combinational.
module fhadd_decode
    import fhadd_pkg::*;
(
    input  logic                 valid_i,
    input  logic [INSN_W-1:0]    word_i,
    input  logic                 dsp_en_i,
    output outcome_t             outcome_o,
    output logic                 rnd_o,
    output logic [RIDX_W-1:0]    src_a_o,
    output logic [RIDX_W-1:0]    src_b_o,
    output logic [RIDX_W-1:0]    dst_o
);

    hadd_word_t fld;
    logic       code_hit;

    assign fld = hadd_word_t'(word_i);

    // Purpose: compare the three fixed code fields against this instruction.
    always_comb begin
        code_hit = (fld.major == MAJOR_CODE) &&
                   (fld.sub   == SUB_CODE)   &&
                   (fld.minor == MINOR_CODE);
    end

    // Purpose: rank the outcomes: idle, reserved, DSP disabled, then write.
    always_comb begin
        if (!valid_i)
            outcome_o = OUTCOME_IDLE;
        else if (!code_hit)
            outcome_o = OUTCOME_RESERVED;
        else if (!dsp_en_i)
            outcome_o = OUTCOME_DSP_OFF;
        else
            outcome_o = OUTCOME_WRITE;
    end

    // Purpose: hand the operand fields to the datapath and register file.
    always_comb begin
        rnd_o   = fld.rnd;
        src_a_o = fld.src_a;
        src_b_o = fld.src_b;
        dst_o   = fld.dst;
    end

endmodule

// File: rtl/fhadd_halve.sv
// Module: fhadd_halve
// Sign-extends two W-bit fractions by one bit and adds them. It adds the
// rounding bit at the bottom and returns the top W bits of the W+1-bit sum.
// The W+1-bit sum cannot overflow, so no saturation is needed.
module fhadd_halve #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         rnd_i,
    output logic [W-1:0] y_o
);

    localparam int SW = W + 1;

    logic [SW-1:0] ext_a;
    logic [SW-1:0] ext_b;
    logic [SW-1:0] total;

    // Purpose: widen both operands by copying their sign bits.
    always_comb begin
        ext_a = {a_i[W-1], a_i};
        ext_b = {b_i[W-1], b_i};
    end

    // Purpose: form the wide sum with the optional +1 at bit 0, then halve.
    always_comb begin
        total = ext_a + ext_b + {{(SW-1){1'b0}}, rnd_i};
        y_o   = total[SW-1:1];
    end

endmodule

// File: rtl/fhadd_regfile.sv
// Module: fhadd_regfile
// DEPTH x W register file with NRD combinational read ports and one write
// port. Entry 0 reads as zero and is never written.
// Reset is synchronous and active-low, and it clears every entry.
module fhadd_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [AW-1:0]       waddr_i,
    input  logic [W-1:0]        wdata_i,
    input  logic [NRD-1:0][AW-1:0] raddr_i,
    output logic [NRD-1:0][W-1:0]  rdata_o
);

    logic [W-1:0] mem [DEPTH];

    // Purpose: clear on reset, else store one word; index 0 is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i && (waddr_i != '0)) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // One combinational read path per port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Purpose: return the entry, forcing zero for index 0.
        always_comb begin
            if (raddr_i[p] == '0) rdata_o[p] = '0;
            else                  rdata_o[p] = mem[raddr_i[p]];
        end
    end

endmodule

// File: rtl/fhadd_unit.sv
// Module: fhadd_unit (top)
// Single-cycle halving-add slice: decode, operand read, halving adder,
// exception outputs and a register-file write at the next rising edge.
// Assumes one instruction per cycle and no pipelining.
module fhadd_unit
    import fhadd_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int REG_CNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [31:0]          instr_word,
    input  logic                 dsp_enable,
    input  logic                 load_en,
    input  logic [4:0]           load_addr,
    input  logic [XLEN-1:0]      load_data,
    output logic                 res_valid,
    output logic [4:0]           res_addr,
    output logic [XLEN-1:0]      res_data,
    output logic                 exc_reserved,
    output logic                 exc_dsp_off
);

    localparam int NRD = 2;

    outcome_t                   outcome;
    logic                       rnd;
    logic [RIDX_W-1:0]          src_a;
    logic [RIDX_W-1:0]          src_b;
    logic [RIDX_W-1:0]          dst;
    logic [NRD-1:0][RIDX_W-1:0] rd_idx;
    logic [NRD-1:0][XLEN-1:0]   rd_val;
    logic [XLEN-1:0]            sum_half;
    logic                       wr_en;
    logic [RIDX_W-1:0]          wr_idx;
    logic [XLEN-1:0]            wr_val;

    fhadd_decode u_dec (
        .valid_i   (instr_valid),
        .word_i    (instr_word),
        .dsp_en_i  (dsp_enable),
        .outcome_o (outcome),
        .rnd_o     (rnd),
        .src_a_o   (src_a),
        .src_b_o   (src_b),
        .dst_o     (dst)
    );

    // Purpose: route the two source indices to the read ports.
    always_comb begin
        rd_idx[0] = src_a;
        rd_idx[1] = src_b;
    end

    fhadd_regfile #(
        .W     (XLEN),
        .DEPTH (REG_CNT),
        .NRD   (NRD)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (wr_idx),
        .wdata_i (wr_val),
        .raddr_i (rd_idx),
        .rdata_o (rd_val)
    );

    fhadd_halve #(.W(XLEN)) u_alu (
        .a_i   (rd_val[0]),
        .b_i   (rd_val[1]),
        .rnd_i (rnd),
        .y_o   (sum_half)
    );

    // Purpose: drive the result port and the two exception flags.
    always_comb begin
        res_valid    = (outcome == OUTCOME_WRITE);
        res_addr     = dst;
        res_data     = sum_half;
        exc_reserved = (outcome == OUTCOME_RESERVED);
        exc_dsp_off  = (outcome == OUTCOME_DSP_OFF);
    end

    // Purpose: merge the result and load requests; a result write wins.
    always_comb begin
        wr_en  = res_valid || load_en;
        wr_idx = res_valid ? dst      : load_addr;
        wr_val = res_valid ? sum_half : load_data;
    end

endmodule

// File: rtl/fhadd_unit_chk.sv
// Module: fhadd_unit_chk
// Port-level temporal checks on fhadd_unit, attached with a bind below.
module fhadd_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            dsp_enable,
    input logic            load_en,
    input logic [4:0]      f_src_b,
    input logic [4:0]      f_src_a,
    input logic [4:0]      f_dst,
    input logic            f_rnd,
    input logic            res_valid,
    input logic [4:0]      res_addr,
    input logic [XLEN-1:0] res_data,
    input logic            exc_reserved,
    input logic            exc_dsp_off
);

    a_r7_exc_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_reserved || exc_dsp_off) |-> instr_valid);

    a_r6_single_exc: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_reserved && exc_dsp_off));

    a_r6_no_write_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_reserved || exc_dsp_off) |-> !res_valid);

    a_r6_disabled_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !dsp_enable) |-> !res_valid);

    a_r1_target_field: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (instr_valid && res_addr == f_dst));

    a_r8_zero_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && f_src_a == 5'd0 && f_src_b == 5'd0) |-> (res_data == '0));

    // R5: a rounded self-copy of the register just written returns that value.
    a_r5_next_sees_write: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_addr != 5'd0) |=>
        (!(res_valid && f_rnd && f_src_a == $past(res_addr) &&
           f_src_b == $past(res_addr)) || (res_data == $past(res_data))));

endmodule

bind fhadd_unit fhadd_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .dsp_enable   (dsp_enable),
    .load_en      (load_en),
    .f_src_b      (instr_word[25:21]),
    .f_src_a      (instr_word[20:16]),
    .f_dst        (instr_word[15:11]),
    .f_rnd        (instr_word[10]),
    .res_valid    (res_valid),
    .res_addr     (res_addr),
    .res_data     (res_data),
    .exc_reserved (exc_reserved),
    .exc_dsp_off  (exc_dsp_off)
);

// File: tb/fhadd_unit_tb.sv
`timescale 1ns/1ps
module fhadd_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        dsp_enable = 1'b1;
    logic        load_en = 1'b0;
    logic [4:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic        res_valid;
    logic [4:0]  res_addr;
    logic [31:0] res_data;
    logic        exc_reserved;
    logic        exc_dsp_off;

    int n_chk = 0;
    int n_bad = 0;

    // Captured outputs of the last issued word.
    logic        o_valid, o_rsv, o_off;
    logic [4:0]  o_addr;
    logic [31:0] o_data;

    always #2.5 clk = ~clk;

    fhadd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .dsp_enable(dsp_enable),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .res_valid(res_valid), .res_addr(res_addr), .res_data(res_data),
        .exc_reserved(exc_reserved), .exc_dsp_off(exc_dsp_off)
    );

    function automatic logic [31:0] enc(input logic [4:0] rt, input logic [4:0] rs,
                                        input logic [4:0] rd, input logic r);
        return {6'b001000, rt, rs, rd, r, 7'b0010001, 3'b101};
    endfunction

    // Reference: signed 64-bit sum, arithmetic shift, low 32 bits.
    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic r);
        longint s;
        s = longint'($signed(a)) + longint'($signed(b)) + longint'(r);
        s = s >>> 1;
        return s[31:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(posedge clk); #1;
        load_en = 1'b0;
    endtask

    // Present one word for one cycle, capture outputs mid-cycle.
    task automatic issue(input logic [31:0] w, input logic en);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w; dsp_enable = en;
        #1;
        o_valid = res_valid; o_addr = res_addr; o_data = res_data;
        o_rsv = exc_reserved; o_off = exc_dsp_off;
        @(posedge clk); #1;
        instr_valid = 1'b0; dsp_enable = 1'b1;
    endtask

    // Readback: rounded self-add with destination 0 returns the value, no write.
    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        issue(enc(a, a, 5'd0, 1'b1), 1'b1);
        v = o_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        load(5'd9, 32'hDEADBEEF);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        #1;
        chk(!res_valid && !exc_reserved && !exc_dsp_off, "R10 idle outputs",
            {29'd0, res_valid, exc_reserved, exc_dsp_off}, 32'd0);
        peek(5'd9, v);
        chk(v == 32'd0, "R10 reset clears reg", v, 32'd0);
    endtask

    task automatic t_plain();
        logic [31:0] av [4] = '{32'h00000005, 32'h40000000, 32'h12345678, 32'hF0000001};
        logic [31:0] bv [4] = '{32'hFFFFFFF8, 32'h20000000, 32'h0FEDCBA9, 32'h80000003};
        for (int i = 0; i < 4; i++) begin
            load(5'd1, av[i]); load(5'd2, bv[i]);
            issue(enc(5'd2, 5'd1, 5'd3, 1'b0), 1'b1);
            chk(o_valid && o_addr == 5'd3, "R1 write strobe/addr", {27'd0, o_addr}, 32'd3);
            chk(o_data == model(av[i], bv[i], 1'b0), "R2 plain result",
                o_data, model(av[i], bv[i], 1'b0));
        end
    endtask

    task automatic t_round();
        logic [31:0] av [3] = '{32'h00000005, 32'h00000003, 32'hA5A5A5A5};
        logic [31:0] bv [3] = '{32'hFFFFFFF8, 32'h00000000, 32'h5A5A5A5A};
        for (int i = 0; i < 3; i++) begin
            load(5'd4, av[i]); load(5'd5, bv[i]);
            issue(enc(5'd5, 5'd4, 5'd6, 1'b1), 1'b1);
            chk(o_data == model(av[i], bv[i], 1'b1), "R3 rounded result",
                o_data, model(av[i], bv[i], 1'b1));
        end
    endtask

    task automatic t_corners();
        load(5'd7, 32'h7FFFFFFF);
        issue(enc(5'd7, 5'd7, 5'd8, 1'b0), 1'b1);
        chk(o_data == 32'h7FFFFFFF, "R4 max+max plain", o_data, 32'h7FFFFFFF);
        load(5'd7, 32'h80000000);
        issue(enc(5'd7, 5'd7, 5'd8, 1'b0), 1'b1);
        chk(o_data == 32'h80000000, "R4 min+min plain", o_data, 32'h80000000);
        issue(enc(5'd7, 5'd7, 5'd8, 1'b1), 1'b1);
        chk(o_data == 32'h80000000, "R4 min+min rounded", o_data, 32'h80000000);
        load(5'd7, 32'hFFFFFFFF);
        issue(enc(5'd0, 5'd7, 5'd8, 1'b0), 1'b1);
        chk(o_data == 32'hFFFFFFFF, "R4 -1+0 plain", o_data, 32'hFFFFFFFF);
        issue(enc(5'd0, 5'd7, 5'd8, 1'b1), 1'b1);
        chk(o_data == 32'h00000000, "R4 -1+0 rounded", o_data, 32'h0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        load(5'd10, 32'h40000000); load(5'd11, 32'h20000000);
        issue(enc(5'd11, 5'd10, 5'd10, 1'b0), 1'b1);
        chk(o_data == 32'h30000000, "R5 dst==src result", o_data, 32'h30000000);
        issue(enc(5'd10, 5'd10, 5'd12, 1'b0), 1'b1);
        chk(o_data == 32'h30000000, "R5 next instr sees write", o_data, 32'h30000000);
        peek(5'd12, v);
        chk(v == 32'h30000000, "R5 stored at edge", v, 32'h30000000);
    endtask

    task automatic t_dsp_off();
        logic [31:0] v;
        load(5'd13, 32'h11111111); load(5'd14, 32'h00000100);
        issue(enc(5'd14, 5'd14, 5'd13, 1'b0), 1'b0);
        chk(o_off && !o_rsv && !o_valid, "R6 dsp-off flags",
            {29'd0, o_off, o_rsv, o_valid}, 32'd4);
        peek(5'd13, v);
        chk(v == 32'h11111111, "R6 no write when disabled", v, 32'h11111111);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        logic [31:0] base;
        logic [31:0] bad [4];
        load(5'd15, 32'h22222222); load(5'd16, 32'h00000400);
        base = enc(5'd16, 5'd16, 5'd15, 1'b0);
        bad[0] = base ^ 32'h04000000;   // major code bit flipped
        bad[1] = base ^ 32'h00000008;   // sub code bit flipped
        bad[2] = base ^ 32'h00000001;   // minor code bit flipped
        bad[3] = base ^ 32'h80000000;   // major code top bit flipped
        for (int i = 0; i < 4; i++) begin
            issue(bad[i], (i % 2 == 0));
            chk(o_rsv && !o_off && !o_valid, "R7 reserved flags",
                {29'd0, o_rsv, o_off, o_valid}, 32'd4);
        end
        peek(5'd15, v);
        chk(v == 32'h22222222, "R7 no write on reserved", v, 32'h22222222);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        load(5'd0, 32'hCAFEF00D);
        peek(5'd0, v);
        chk(v == 32'd0, "R8 load to r0 ignored", v, 32'd0);
        load(5'd17, 32'h7FFFFFFF);
        issue(enc(5'd17, 5'd17, 5'd0, 1'b0), 1'b1);
        peek(5'd0, v);
        chk(v == 32'd0, "R8 result to r0 ignored", v, 32'd0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        load(5'd18, 32'h00000010); load(5'd19, 32'h55555555); load(5'd20, 32'h66666666);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = enc(5'd18, 5'd18, 5'd19, 1'b0);
        load_en = 1'b1; load_addr = 5'd20; load_data = 32'h99999999;
        @(posedge clk); #1;
        instr_valid = 1'b0; load_en = 1'b0;
        peek(5'd19, v);
        chk(v == 32'h00000010, "R9 result written", v, 32'h10);
        peek(5'd20, v);
        chk(v == 32'h66666666, "R9 colliding load dropped", v, 32'h66666666);
        load(5'd21, 32'h0BADCAFE);
        peek(5'd21, v);
        chk(v == 32'h0BADCAFE, "R9 plain load", v, 32'h0BADCAFE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_plain();
        t_round();
        t_corners();
        t_chain();
        t_dsp_off();
        t_reserved();
        t_zero();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule